// File: doc/BRIEF.md
# Main Endpoint DMA Request Controller

This block produces the request line that an external demand-mode DMA controller follows when moving data to or from the main (double-buffered) endpoint of a USB device controller. It reads the state of that endpoint from the buffer manager: whether a received packet is waiting, whether the transmit buffer has room, and whether the byte now moving is the last one of its packet or buffer. It counts acknowledged transfers against a programmed burst length.

A one-byte configuration register holds the enable, the direction, the burst code and an auto-reload bit. An end-of-transfer input is honoured only during a real transfer cycle. It stops the operation, or restarts it when auto-reload is set. It also flushes a partly filled transmit buffer and raises a completion flag on the active-low interrupt output. While the DMA acknowledge is low, the endpoint selection passed to the buffer manager is forced to the main endpoint.

Top module: `usb_ep_dma_req`

## Requirements
- R1: After reset the configuration readback `cfg_q` is 0x00. A write on `cfg_wr` stores the whole byte, and `cfg_q` shows it from the next cycle.
- R2: Field positions are enable = bit 2, direction = bit 3, auto-reload = bit 4 and burst code = bits 1:0. With enable set and the endpoint ready, `dreq` rises two cycles after the write cycle. Writing a byte with bit 2 clear drops `dreq` in the cycle after the write, even in the middle of a burst.
- R3: In single-cycle mode (burst code 00), `dreq` is low during the cycle of each acknowledged transfer. It stays low for one more cycle after the acknowledge is released, then rises again if the endpoint is still ready.
- R4: Burst codes 00, 01, 10 and 11 allow 1, 4, 8 and 16 transfers. `dreq` stays high through the first N-1 transfers and is low during the Nth. It then rises again with a fresh count.
- R5: In read direction (bit 3 = 0), `dreq` is high only while `buf_full` is high.
- R6: In write direction (bit 3 = 1), `dreq` is high only while `tx_full` is low. If the request is withdrawn part-way through a burst because of `tx_full`, the next request starts a full new burst.
- R7: A transfer that carries `pkt_last` ends the request whatever burst count remains. The next request gets a full burst count.
- R8: End-of-transfer counts only when `eot_n`, `dack_n` and one of `rd_n`/`wr_n` are low in the same cycle. Otherwise it has no effect. When it counts, it clears bit 2 of the configuration, unless bit 4 is set, and it sets the completion flag.
- R9: A qualified end-of-transfer in write direction pulses `tx_flush` high for exactly one cycle, in the cycle after it. In read direction `tx_flush` stays low.
- R10: `irq_n` is low while the completion flag is set. A pulse on `irq_ack` clears the flag. If a qualified end-of-transfer arrives in the same cycle as `irq_ack`, the flag stays set.
- R11: `ep_sel` equals the main endpoint number (default 2) while `dack_n` is low, and equals `cpu_ep` otherwise.
- R12: With auto-reload set, a qualified end-of-transfer leaves the enable bit set, and `dreq` rises again without any configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte to write |
| cfg_q | output | 8 | Configuration readback |
| irq_ack | input | 1 | CPU read of the interrupt register; clears the completion flag |
| buf_full | input | 1 | A received packet is waiting in the endpoint buffer |
| tx_full | input | 1 | The transmit buffer is full |
| pkt_last | input | 1 | The current transfer moves the last byte of the packet or buffer |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| eot_n | input | 1 | End of transfer, active low |
| cpu_ep | input | EP_W | Endpoint the CPU has selected |
| dreq | output | 1 | DMA request |
| irq_n | output | 1 | Completion interrupt, active low |
| tx_flush | output | 1 | One-cycle pulse that releases a partly filled transmit buffer |
| ep_sel | output | EP_W | Endpoint selection passed to the buffer manager |

## Verification
The assertions assume that each strobe pulse with `dack_n` low is exactly one transfer per clock. They also assume that `buf_full`, `tx_full` and `pkt_last` are driven synchronously by the buffer manager, and that a configuration write never falls in the same cycle as a qualified end-of-transfer. The stimulus drives every input on the falling clock edge, holds each strobe for one cycle, and asserts `pkt_last` and `eot_n` only together with a strobe. Configuration writes are placed in idle cycles, and the endpoint-state inputs are toggled only between transfers.

// File: rtl/usb_ep_dma_req.sv
module usb_ep_dma_req #(
  parameter int EP_W = 3,
  parameter logic [EP_W-1:0] MAIN_EP = 3'd2,
  parameter int CNT_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_q,
  input  logic            irq_ack,
  input  logic            buf_full,
  input  logic            tx_full,
  input  logic            pkt_last,
  input  logic            dack_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            eot_n,
  input  logic [EP_W-1:0] cpu_ep,
  output logic            dreq,
  output logic            irq_n,
  output logic            tx_flush,
  output logic [EP_W-1:0] ep_sel
);

  logic [7:0]       cfg;
  logic             req_on, done_flag, flush_q;
  logic [CNT_W-1:0] cnt, blen;
  logic             en, dir, arl, xfer, eot_hit, ready, last_one;

  assign en  = cfg[2];
  assign dir = cfg[3];
  assign arl = cfg[4];

  always_comb begin
    case (cfg[1:0])
      2'd0:    blen = CNT_W'(1);
      2'd1:    blen = CNT_W'(4);
      2'd2:    blen = CNT_W'(8);
      default: blen = CNT_W'(16);
    endcase
  end

  assign xfer     = ~dack_n & (~rd_n | ~wr_n);
  assign eot_hit  = xfer & ~eot_n;
  assign ready    = dir ? ~tx_full : buf_full;
  assign last_one = xfer & ((cnt == CNT_W'(1)) | pkt_last | eot_hit);

  assign dreq     = req_on & en & ready & ~last_one;
  assign cfg_q    = cfg;
  assign irq_n    = ~done_flag;
  assign tx_flush = flush_q;
  assign ep_sel   = dack_n ? cpu_ep : MAIN_EP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= 8'h00;
    else if (cfg_wr) cfg <= cfg_wdata;
    else if (eot_hit && !arl) cfg[2] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_on <= 1'b0;
      cnt    <= '0;
    end else if (!en || !ready || (req_on && last_one)) begin
      req_on <= 1'b0;
    end else if (!req_on && dack_n) begin
      req_on <= 1'b1;
      cnt    <= blen;
    end else if (req_on && xfer) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      flush_q   <= 1'b0;
    end else begin
      flush_q <= eot_hit & dir;
      if (eot_hit) done_flag <= 1'b1;
      else if (irq_ack) done_flag <= 1'b0;
    end
  end

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[2] |-> !dreq);
  p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_on |-> (cnt != '0 && cnt <= CNT_W'(16)));
  p_read_needs_packet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && !cfg_q[3]) |-> buf_full);
  p_write_needs_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && cfg_q[3]) |-> !tx_full);
  p_last_byte_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && pkt_last) |=> !dreq);
  p_eot_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eot_hit |=> !irq_n);
  p_flush_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_hit && cfg_q[3]) |=> tx_flush);
  p_no_flush_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_hit && !cfg_q[3]) |=> !tx_flush);
  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !eot_hit) |=> irq_n);
  p_main_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dack_n |-> ep_sel == MAIN_EP);

endmodule

// File: tb/sim_usb_ep_dma_req.sv
module sim_usb_ep_dma_req;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, irq_ack = 0, buf_full = 0, tx_full = 0, pkt_last = 0;
  logic dack_n = 1, rd_n = 1, wr_n = 1, eot_n = 1;
  logic [7:0] cfg_wdata = 0, cfg_q;
  logic [2:0] cpu_ep = 0, ep_sel;
  logic dreq, irq_n, tx_flush;
  int checks = 0, fails = 0;
  bit dq;
  int n;

  always #2 clk = ~clk;

  usb_ep_dma_req u0 (.clk, .rst_n, .cfg_wr, .cfg_wdata, .cfg_q, .irq_ack,
    .buf_full, .tx_full, .pkt_last, .dack_n, .rd_n, .wr_n, .eot_n, .cpu_ep,
    .dreq, .irq_n, .tx_flush, .ep_sel);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgw(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0; #1;
  endtask

  task automatic xfer(input bit wr, input bit last, input bit eot, output bit d);
    @(negedge clk); dack_n = 0; rd_n = wr; wr_n = !wr; pkt_last = last; eot_n = !eot;
    #1 d = dreq;
  endtask

  task automatic rel();
    @(negedge clk); dack_n = 1; rd_n = 1; wr_n = 1; pkt_last = 0; eot_n = 1; #1;
  endtask

  task automatic burst(input bit wr, output int cnt_o);
    bit d;
    cnt_o = 0; d = 1;
    while (d && cnt_o < 40) begin
      xfer(wr, 0, 0, d);
      cnt_o++;
    end
    rel();
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  initial begin
    #(4 * 100000);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #9 rst_n = 1;
    #1;
    chk(cfg_q == 0 && !dreq && irq_n && !tx_flush, "R1 reset", cfg_q, 0);
    cfgw(8'hA1);
    chk(cfg_q == 8'hA1, "R1 readback", cfg_q, 8'hA1);
    cfgw(8'h00);

    buf_full = 1; tx_full = 0;
    for (int d = 0; d < 2; d++) begin
      for (int b = 0; b < 4; b++) begin
        int exp;
        exp = (b == 0) ? 1 : (2 ** (b + 1));
        cfgw({4'b0, d[0], 1'b1, b[1:0]});
        chk(!dreq, "R2 not yet", dreq, 0);
        step();
        chk(dreq, "R2 armed", dreq, 1);
        for (int r = 0; r < 2; r++) begin
          burst(d[0], n);
          chk(n == exp, b == 0 ? "R3 single length" : "R4 burst length", n, exp);
          chk(!dreq, "R3 gap after burst", dreq, 0);
          step();
          chk(dreq, "R4 re-raise", dreq, 1);
        end
        cfgw(8'h00);
      end
    end

    cfgw(8'h04); buf_full = 0;
    step(); step();
    chk(!dreq, "R5 empty buffer", dreq, 0);
    buf_full = 1; step();
    chk(dreq, "R5 packet ready", dreq, 1);
    cfgw(8'h00);

    tx_full = 1; cfgw(8'h0E); step(); step();
    chk(!dreq, "R6 full tx buffer", dreq, 0);
    tx_full = 0; step();
    chk(dreq, "R6 room", dreq, 1);
    for (int i = 0; i < 3; i++) xfer(1, 0, 0, dq);
    rel();
    @(negedge clk); tx_full = 1; #1;
    chk(!dreq, "R6 withdraw", dreq, 0);
    @(negedge clk); tx_full = 0; step();
    burst(1, n);
    chk(n == 8, "R6 fresh count", n, 8);
    cfgw(8'h00);

    cfgw(8'h07); step();
    xfer(0, 0, 0, dq); xfer(0, 0, 0, dq);
    xfer(0, 1, 0, dq);
    chk(!dq, "R7 cut at last byte", dq, 0);
    rel();
    chk(!dreq, "R7 low after cut", dreq, 0);
    step();
    burst(0, n);
    chk(n == 16, "R7 fresh count", n, 16);

    @(negedge clk); eot_n = 0;
    @(negedge clk); dack_n = 0;
    @(negedge clk); eot_n = 1; dack_n = 1; #1;
    step();
    chk(irq_n && cfg_q[2] && dreq, "R8 unqualified eot ignored", {irq_n, cfg_q[2], dreq}, 7);
    xfer(0, 0, 1, dq);
    chk(!dq, "R8 eot drops request", dq, 0);
    rel();
    chk(!irq_n && !cfg_q[2], "R8 eot effects", {irq_n, cfg_q[2]}, 0);
    chk(!tx_flush, "R9 no flush in read", tx_flush, 0);
    step(); step();
    chk(!dreq, "R8 stays off", dreq, 0);
    chk(!irq_n, "R10 flag held", irq_n, 0);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0; #1;
    chk(irq_n, "R10 cleared", irq_n, 1);

    cfgw(8'h0C); step();
    xfer(1, 0, 1, dq);
    @(negedge clk); dack_n = 1; wr_n = 1; eot_n = 1; irq_ack = 1; #1;
    chk(tx_flush, "R9 flush pulse", tx_flush, 1);
    @(negedge clk); irq_ack = 0; #1;
    chk(!tx_flush, "R9 flush one cycle", tx_flush, 0);
    chk(irq_n, "R10 ack clears later", irq_n, 1);

    cfgw(8'h17); step();
    xfer(0, 0, 1, dq); rel();
    chk(cfg_q[2] && !irq_n, "R12 enable kept", {cfg_q[2], irq_n}, 2);
    step();
    chk(dreq, "R12 re-armed", dreq, 1);
    @(negedge clk); irq_ack = 1; @(negedge clk); irq_ack = 0;

    xfer(0, 0, 0, dq); xfer(0, 0, 0, dq); rel();
    cfgw(8'h03);
    chk(!dreq && cfg_q == 8'h03, "R2 abort", dreq, 0);

    for (int e = 0; e < 8; e++) begin
      @(negedge clk); cpu_ep = e[2:0]; dack_n = 0; #1;
      chk(ep_sel == 3'd2, "R11 main forced", ep_sel, 2);
      @(negedge clk); dack_n = 1; #1;
      chk(ep_sel == e[2:0], "R11 cpu choice", ep_sel, e);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule